// File: doc/BRIEF.md
# GPIO Interrupt Slot Multiplexer

This block turns a wide set of GPIO input pins into one interrupt line through eight shared interrupt slots. Each slot picks one pin from four ports (A, B, C and D), watches it for a level or an edge, and holds a pending flag that software can mask and, for edge modes, acknowledge. The eight masked flags are ORed into a single interrupt output.

Pins are grouped into 8-pin slices. Slot k always watches bit k of the slice its 4-bit selector names. The selector value is `4*port + pin/8`, with A=0, B=1, C=2 and D=3. For example, pin 19 of port B is watched by slot 3 with selector 6. Port C has only 16 pins, so its upper two slices do not exist. All pins pass through a two-flop synchroniser before they are used.

A flat 32-bit register interface with byte offsets holds the configuration. A write takes effect on the clock edge at which `wr_en` is sampled high. A read returns data combinationally for the address that is currently applied.

Top module: `gpio_irq_mux`

## Requirements
- R1: After reset, the trigger, selector and mask registers read 0. The raw and masked status read 0 and `irq_out` is low.
- R2: Register layout:
  - Offset 120 holds the trigger codes, 3 bits per slot, with slot k at [3k+2:3k]. Bits [31:24] read 0.
  - Offset 124 holds the selectors, 4 bits per slot, with slot k at [4k+3:4k].
  - Offset 128 holds the mask in [7:0]. Its upper bits read 0.
  - Offset 132 (acknowledge) reads 0, and so does every undefined offset.
- R3: Slot k with selector s watches bit `(s%4)*8+k` of port `s/4`. Selectors 10 and 11 point to the missing upper slices of port C, and the slot then sees a constant 0.
- R4: Level modes:
  - Code 1 makes the raw bit equal the synchronised pin.
  - Code 2 makes the raw bit equal the inverse of the synchronised pin.
  - In both modes the raw bit follows the pin with a latency of two clock edges.
- R5: Edge modes are code 5 (rising), code 6 (falling) and code 7 (either edge). A matching edge sets the slot's pending latch. The latch stays set when the pin returns, until it is acknowledged.
- R6: Acknowledge register (offset 132):
  - Writing 1 to bit k clears the edge latch of slot k. Writing 0 has no effect.
  - In level modes an acknowledge has no lasting effect.
  - If an edge and an acknowledge arrive in the same cycle, the edge wins.
- R7: Code 3 forces the raw bit to 1. Codes 0 and 4 force it to 0 and clear any edge latch.
- R8: Status and interrupt:
  - Offset 136 reads the raw pending bits in [7:0].
  - Offset 140 reads the raw bits ANDed with the mask.
  - `irq_out` is the OR of the masked bits.
- R9: Writes to offsets 136 and 140 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| port_a_in | input | 32 | Port A pin levels |
| port_b_in | input | 32 | Port B pin levels |
| port_c_in | input | 16 | Port C pin levels |
| port_d_in | input | 32 | Port D pin levels (input-only port) |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench targets the following corner cases. For each one it states what a faulty design would show.

- **Slice arithmetic.** The bench places a slot on a slice in port B and on a slice in port D. A design that swapped the slice and lane bits would watch the wrong pin.
- **Missing port C slices.** The bench points a slot at a missing port C slice in active-low mode. That slot must read a steady 1 even while every port C pin is high. A design that wrapped the index would read real pins there.
- **Edge latches.** The bench returns the pin to its idle level after each edge and expects the latch to hold. It then checks that a zero acknowledge leaves the latch set and that a one clears it. A design that followed the pin, or cleared the latch on any write, would lose the event.
- **Read-only status and off codes.** The bench writes to the status offsets and expects nothing to change. It also checks that the reserved code 4 behaves like off.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int NUM_SLOTS = 8;
    localparam int MODE_W    = 3;
    localparam int SEL_W     = 4;
    localparam int LANE_W    = $clog2(NUM_SLOTS);
    localparam int PORT_SPAN = 4 * NUM_SLOTS;           // four slices per port
    localparam int PIN_VEC_W = (1 << SEL_W) * NUM_SLOTS; // every selector value

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_TRIG   = 8'd120;
    localparam logic [ADDR_W-1:0] OFF_SEL    = 8'd124;
    localparam logic [ADDR_W-1:0] OFF_MASK   = 8'd128;
    localparam logic [ADDR_W-1:0] OFF_ACK    = 8'd132;
    localparam logic [ADDR_W-1:0] OFF_RAW    = 8'd136;
    localparam logic [ADDR_W-1:0] OFF_MASKED = 8'd140;

    typedef enum logic [MODE_W-1:0] {
        TRIG_OFF    = 3'd0,
        TRIG_LVL_HI = 3'd1,
        TRIG_LVL_LO = 3'd2,
        TRIG_FORCE  = 3'd3,
        TRIG_RSV    = 3'd4,
        TRIG_RISE   = 3'd5,
        TRIG_FALL   = 3'd6,
        TRIG_BOTH   = 3'd7
    } trig_mode_e;

    typedef struct packed {
        trig_mode_e       mode;
        logic [SEL_W-1:0] sel;
    } slot_cfg_t;

    function automatic logic is_edge_mode(trig_mode_e m);
        return (m == TRIG_RISE) || (m == TRIG_FALL) || (m == TRIG_BOTH);
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign d_sync = stage2_q;
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [NUM_SLOTS-1:0]  raw_status,
    output logic [DATA_W-1:0]     rdata,
    output slot_cfg_t             slot_cfg [NUM_SLOTS],
    output logic [NUM_SLOTS-1:0]  ack_pulse,
    output logic [NUM_SLOTS-1:0]  masked_status
);
    localparam int TRIG_W = NUM_SLOTS * MODE_W;
    localparam int SELB_W = NUM_SLOTS * SEL_W;

    logic [TRIG_W-1:0]    trig_q;
    logic [SELB_W-1:0]    sel_q;
    logic [NUM_SLOTS-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= '0;
            sel_q  <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            case (addr)
                OFF_TRIG: trig_q <= wdata[TRIG_W-1:0];
                OFF_SEL:  sel_q  <= wdata[SELB_W-1:0];
                OFF_MASK: mask_q <= wdata[NUM_SLOTS-1:0];
                default:  ;
            endcase
        end
    end

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_cfg
        assign slot_cfg[k].mode = trig_mode_e'(trig_q[k*MODE_W +: MODE_W]);
        assign slot_cfg[k].sel  = sel_q[k*SEL_W +: SEL_W];
    end

    assign ack_pulse     = (wr_en && addr == OFF_ACK) ? wdata[NUM_SLOTS-1:0] : '0;
    assign masked_status = raw_status & mask_q;

    always_comb begin
        rdata = '0;
        case (addr)
            OFF_TRIG:   rdata[TRIG_W-1:0]    = trig_q;
            OFF_SEL:    rdata[SELB_W-1:0]    = sel_q;
            OFF_MASK:   rdata[NUM_SLOTS-1:0] = mask_q;
            OFF_RAW:    rdata[NUM_SLOTS-1:0] = raw_status;
            OFF_MASKED: rdata[NUM_SLOTS-1:0] = masked_status;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_slot.sv
module gpio_irq_slot
    import gpio_irq_pkg::*;
#(
    parameter int SLOT_IDX = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PIN_VEC_W-1:0] pin_vec,
    input  slot_cfg_t            cfg,
    input  logic                 ack,
    output logic                 raw
);
    localparam logic [LANE_W-1:0] LANE = LANE_W'(SLOT_IDX);

    logic [SEL_W+LANE_W-1:0] pick_idx;
    logic pin_now;
    logic pin_prev_q;
    logic pend_q;
    logic rise, fall, hit;

    assign pick_idx = {cfg.sel, LANE};
    assign pin_now  = pin_vec[pick_idx];
    assign rise     = pin_now & ~pin_prev_q;
    assign fall     = ~pin_now & pin_prev_q;

    always_comb begin
        case (cfg.mode)
            TRIG_RISE: hit = rise;
            TRIG_FALL: hit = fall;
            TRIG_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_prev_q <= 1'b0;
            pend_q     <= 1'b0;
        end else begin
            pin_prev_q <= pin_now;
            if (!is_edge_mode(cfg.mode)) pend_q <= 1'b0;
            else if (hit)                pend_q <= 1'b1;   // edge beats ack
            else if (ack)                pend_q <= 1'b0;
        end
    end

    always_comb begin
        case (cfg.mode)
            TRIG_LVL_HI: raw = pin_now;
            TRIG_LVL_LO: raw = ~pin_now;
            TRIG_FORCE:  raw = 1'b1;
            TRIG_RISE, TRIG_FALL, TRIG_BOTH: raw = pend_q;
            default:     raw = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_mux.sv
module gpio_irq_mux
    import gpio_irq_pkg::*;
#(
    parameter int A_W = 32,
    parameter int B_W = 32,
    parameter int C_W = 16,
    parameter int D_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [A_W-1:0]    port_a_in,
    input  logic [B_W-1:0]    port_b_in,
    input  logic [C_W-1:0]    port_c_in,
    input  logic [D_W-1:0]    port_d_in,
    output logic              irq_out
);
    logic [PIN_VEC_W-1:0] pin_flat;
    logic [PIN_VEC_W-1:0] pin_sync;
    slot_cfg_t            slot_cfg [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] ack_pulse;
    logic [NUM_SLOTS-1:0] raw_status;
    logic [NUM_SLOTS-1:0] masked_status;
    logic [NUM_SLOTS*MODE_W-1:0] trig_view;

    // Each port owns PORT_SPAN bits; missing slices read as 0.
    assign pin_flat[0*PORT_SPAN +: A_W] = port_a_in;
    assign pin_flat[1*PORT_SPAN +: B_W] = port_b_in;
    assign pin_flat[2*PORT_SPAN +: C_W] = port_c_in;
    assign pin_flat[3*PORT_SPAN +: D_W] = port_d_in;
    if (A_W < PORT_SPAN) begin : g_pad_a
        assign pin_flat[0*PORT_SPAN+A_W +: PORT_SPAN-A_W] = '0;
    end
    if (B_W < PORT_SPAN) begin : g_pad_b
        assign pin_flat[1*PORT_SPAN+B_W +: PORT_SPAN-B_W] = '0;
    end
    if (C_W < PORT_SPAN) begin : g_pad_c
        assign pin_flat[2*PORT_SPAN+C_W +: PORT_SPAN-C_W] = '0;
    end
    if (D_W < PORT_SPAN) begin : g_pad_d
        assign pin_flat[3*PORT_SPAN+D_W +: PORT_SPAN-D_W] = '0;
    end

    gpio_irq_sync #(.WIDTH(PIN_VEC_W)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pin_flat),
        .d_sync  (pin_sync)
    );

    gpio_irq_regs u_regs (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .addr          (addr),
        .wdata         (wdata),
        .raw_status    (raw_status),
        .rdata         (rdata),
        .slot_cfg      (slot_cfg),
        .ack_pulse     (ack_pulse),
        .masked_status (masked_status)
    );

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        gpio_irq_slot #(.SLOT_IDX(k)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .pin_vec (pin_sync),
            .cfg     (slot_cfg[k]),
            .ack     (ack_pulse[k]),
            .raw     (raw_status[k])
        );
        assign trig_view[k*MODE_W +: MODE_W] = slot_cfg[k].mode;
    end

    assign irq_out = |masked_status;
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker
    import gpio_irq_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic                        wr_en,
    input logic [ADDR_W-1:0]           addr,
    input logic [DATA_W-1:0]           wdata,
    input logic [DATA_W-1:0]           rdata,
    input logic                        irq_out,
    input logic [NUM_SLOTS-1:0]        raw_q,
    input logic [NUM_SLOTS*MODE_W-1:0] cfg_q
);
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !irq_out);

    assert_ack_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (addr == OFF_ACK) |-> (rdata == '0));

    assert_irq_matches_masked_R8: assert property (@(posedge clk) disable iff (rst)
        (addr == OFF_MASKED) |-> (irq_out == (rdata[NUM_SLOTS-1:0] != '0)));

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_chk
        assert_latch_holds_R5: assert property (@(posedge clk) disable iff (rst)
            (raw_q[k] && cfg_q[k*MODE_W +: MODE_W] >= 3'd5
             && !(wr_en && addr == OFF_ACK && wdata[k])
             && !(wr_en && addr == OFF_TRIG)) |=> raw_q[k]);

        assert_force_high_R7: assert property (@(posedge clk) disable iff (rst)
            (cfg_q[k*MODE_W +: MODE_W] == 3'd3) |-> raw_q[k]);
    end
endmodule

bind gpio_irq_mux gpio_irq_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .irq_out (irq_out),
    .raw_q   (raw_status),
    .cfg_q   (trig_view)
);

// File: tb/tb_gpio_irq_mux.sv
module tb_gpio_irq_mux;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] pa = '0, pb = '0, pd = '0;
    logic [15:0] pc = '0;
    logic        irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_mux dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .port_a_in(pa), .port_b_in(pb), .port_c_in(pc),
        .port_d_in(pd), .irq_out(irq_out)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
        addr = '0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic clean();
        wr(8'd120, 0); wr(8'd124, 0); wr(8'd128, 0);
        pa = '0; pb = '0; pc = '0; pd = '0;
        settle();
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'd120, d); check("R1", "trig", d, 0);
        rd(8'd124, d); check("R1", "sel", d, 0);
        rd(8'd128, d); check("R1", "mask", d, 0);
        rd(8'd136, d); check("R1", "raw", d, 0);
        rd(8'd140, d); check("R1", "masked", d, 0);
        check("R1", "irq", {31'd0, irq_out}, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(8'd124, 32'h1234_5678); rd(8'd124, d); check("R2", "sel readback", d, 32'h1234_5678);
        wr(8'd128, 32'hFFFF_FFFF); rd(8'd128, d); check("R2", "mask width", d, 32'h0000_00FF);
        wr(8'd120, 32'hFFFF_FFFF); rd(8'd120, d); check("R2", "trig width", d, 32'h00FF_FFFF);
        rd(8'd132, d); check("R2", "ack reads 0", d, 0);
        rd(8'd100, d); check("R2", "undefined offset", d, 0);
        clean();
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(8'd120, 32'(1) << 3);     // slot 1 code 1, selector 0 -> A[1]
        pa[1] = 1'b1; settle();
        rd(8'd136, d); check("R4", "level high set", d, 32'h02);
        pa[1] = 1'b0; settle();
        rd(8'd136, d); check("R4", "level high clear", d, 0);
        wr(8'd120, 32'(2) << 3);
        settle();
        rd(8'd136, d); check("R4", "level low", d, 32'h02);
        clean();
    endtask

    task automatic t_select();
        logic [31:0] d;
        // slot 3 -> selector 6 (B[19]); slot 0 -> selector 12 (D[0]); slot 2 -> selector 10 (missing C slice)
        wr(8'd124, (32'd6 << 12) | (32'd12 << 0) | (32'd10 << 8));
        wr(8'd120, (32'd1 << 9) | (32'd1 << 0) | (32'd2 << 6));
        pa = '1; pc = '1; settle();
        rd(8'd136, d); check("R3", "no B/D pin, C missing", d, 32'h04);
        pb[19] = 1'b1; pd[0] = 1'b1; settle();
        rd(8'd136, d); check("R3", "B19 and D0 selected", d, 32'h0D);
        clean();
    endtask

    task automatic t_edges();
        logic [31:0] d;
        // slot 4 rise, slot 5 fall, slot 6 both; all selector 0 -> A[4],A[5],A[6]
        wr(8'd120, (32'd5 << 12) | (32'd6 << 15) | (32'd7 << 18));
        settle();
        rd(8'd136, d); check("R5", "no edge yet", d, 0);
        pa[4] = 1; pa[5] = 1; pa[6] = 1; settle();
        rd(8'd136, d); check("R5", "after rising", d, 32'h50);
        pa[4] = 0; pa[5] = 0; pa[6] = 0; settle();
        rd(8'd136, d); check("R5", "latched after falling", d, 32'h70);
        wr(8'd132, 32'h0000_0000); settle();
        rd(8'd136, d); check("R6", "ack zero no effect", d, 32'h70);
        wr(8'd132, 32'h0000_0010);
        rd(8'd136, d); check("R6", "ack slot 4", d, 32'h60);
        wr(8'd132, 32'h0000_0060);
        rd(8'd136, d); check("R6", "ack slots 5,6", d, 0);
        clean();
    endtask

    task automatic t_level_ack();
        logic [31:0] d;
        wr(8'd120, 32'd1);           // slot 0 level high on A[0]
        pa[0] = 1; settle();
        wr(8'd132, 32'h01); settle();
        rd(8'd136, d); check("R6", "ack in level mode", d, 32'h01);
        clean();
    endtask

    task automatic t_force_off();
        logic [31:0] d;
        wr(8'd120, 32'd3 << 21);     // slot 7 forced
        rd(8'd136, d); check("R7", "forced set", d, 32'h80);
        pa[7] = 1; wr(8'd120, 32'd4 << 21); settle();
        rd(8'd136, d); check("R7", "code 4 off", d, 0);
        pa[7] = 0; wr(8'd120, 32'd5 << 21); settle();
        pa[7] = 1; settle();
        rd(8'd136, d); check("R7", "edge latched", d, 32'h80);
        wr(8'd120, 0);
        wr(8'd120, 32'd5 << 21);
        rd(8'd136, d); check("R7", "off clears latch", d, 0);
        clean();
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(8'd120, (32'd3 << 21) | (32'd3 << 0));   // slots 7 and 0 forced
        rd(8'd140, d); check("R8", "masked with mask 0", d, 0);
        check("R8", "irq with mask 0", {31'd0, irq_out}, 0);
        wr(8'd128, 32'h80);
        rd(8'd140, d); check("R8", "masked slot 7", d, 32'h80);
        rd(8'd136, d); check("R8", "raw unmasked", d, 32'h81);
        check("R8", "irq with mask", {31'd0, irq_out}, 1);
        wr(8'd140, 32'hFF); wr(8'd136, 32'h00);
        rd(8'd128, d); check("R9", "mask kept", d, 32'h80);
        rd(8'd136, d); check("R9", "raw kept", d, 32'h81);
        rd(8'd120, d); check("R9", "trig kept", d, (32'd3 << 21) | 32'd3);
        clean();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_level();
        t_select();
        t_edges();
        t_level_ack();
        t_force_off();
        t_mask();
        summary();
    end
endmodule